// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This block takes received characters, one byte at a time, and stores them in memory buffers handed out through a ring of buffer descriptors held in memory. For each buffer it reads the descriptor, checks that software has marked it empty, and loads the buffer start address into a data pointer. It also loads a byte down-counter from a shared maximum-length register. Each accepted byte becomes one byte write at the data pointer. The buffer is closed when the counter runs out, when a byte carries the end-of-frame flag, or when the error flag is raised. Closing writes the status and the stored byte count back into the descriptor, and the engine then steps to the next entry.

The ring occupies consecutive 8-byte entries starting at a programmable base. The entry marked with the wrap flag is the last one, and after it the pointer returns to the base. A new maximum length only applies when the next buffer is opened. When the engine reaches a descriptor that software has not yet returned, it raises a busy indication, drops incoming bytes, and keeps polling that entry until it is empty again.

Top module: `rxbd_engine`

## Requirements
- R1: After reset the engine issues no memory request and busy is low. Configuration writes use selector 0 for maximum length, 1 for ring base, 2 for descriptor pointer and 3 for enable (bit 0). Once enabled, the first descriptor read is at the reset base address (parameter, default 0x100).
- R2: A descriptor is two 32-bit little-endian words. Word 0 is at the descriptor pointer and holds bit 31 empty, bit 30 wrap, bit 29 last-in-frame, bit 28 error and bits 15:0 length. Word 1 is at pointer+4 and holds the buffer address. Entries are 8 bytes apart.
- R3: Every stored byte is written as a single-byte memory write at the data pointer. Successive bytes of one buffer go to consecutive addresses, starting at the buffer address.
- R4: A buffer closes after exactly the maximum-length number of bytes. The close writes word 0 with empty, last and error clear, the wrap bit preserved, and length equal to the maximum.
- R5: A byte carrying end-of-frame is stored, and the buffer then closes with last set and length equal to the bytes stored. If end-of-frame falls on the byte that reaches the limit, exactly one close occurs, with last set and length equal to the maximum.
- R6: A byte carrying the error flag is not stored. The buffer closes with error set and length equal to the bytes stored before it.
- R7: After a close the descriptor pointer advances by 8. If the closed entry had wrap set, it reloads the ring base instead.
- R8: A maximum-length write takes effect only for buffers opened after it, and the buffer in progress keeps its limit. A write of zero is ignored.
- R9: A descriptor-pointer write is ignored while a buffer is open. It is accepted while the engine is disabled or is polling for a descriptor.
- R10: When a fetched descriptor is not empty, busy goes high, incoming bytes are discarded and the entry is re-read. Once it reads as empty, busy falls and reception continues in that buffer.
- R11: Bytes that arrive while the engine is disabled are discarded, and no memory request is issued while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration register selector |
| cfgWrData | input | ADDR_W | Configuration write data |
| rxValid | input | 1 | Received byte valid (one cycle per byte) |
| rxData | input | 8 | Received byte |
| rxEof | input | 1 | Byte ends a frame |
| rxErr | input | 1 | Byte is flagged in error |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWrite | output | 1 | 1 = write, 0 = read |
| memByte | output | 1 | 1 = single-byte write, 0 = 32-bit word |
| memAddr | output | ADDR_W | Memory byte address |
| memWData | output | 32 | Write data (byte in bits 7:0) |
| memAck | input | 1 | Request completed; read data valid |
| memRData | input | 32 | Read data |
| rxBusy | output | 1 | No empty descriptor available |

## Verification
Two of the close conditions can hit the same byte: the end-of-frame flag can arrive on the very byte that exhausts the down-counter. The bench provokes this by sending a frame whose length equals the maximum exactly. It then judges that the descriptor shows one close with last set and a full length, and that the following descriptor is still marked empty, with no zero-length close. A second pairing puts a pointer write on top of an open buffer, and the close address shows whether the write was refused.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  localparam int EMPTY_BIT   = 31;
  localparam int WRAP_BIT    = 30;
  localparam int LAST_BIT    = 29;
  localparam int ERR_BIT     = 28;
  localparam int DESC_STRIDE = 8;
  localparam int WORD1_OFS   = 4;

  localparam logic [1:0] SEL_MAXLEN = 2'd0;
  localparam logic [1:0] SEL_BASE   = 2'd1;
  localparam logic [1:0] SEL_DPTR   = 2'd2;
  localparam logic [1:0] SEL_ENABLE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH0,
    ST_FETCH1,
    ST_OPEN,
    ST_WRITE,
    ST_CLOSE
  } rxState_t;

  typedef enum logic [1:0] {
    ASEL_DESC0,
    ASEL_DESC1,
    ASEL_DATA
  } addrSel_t;

  typedef struct packed {
    logic takeHeader;
    logic openBuffer;
    logic captureByte;
    logic byteDone;
    logic closeDone;
    logic setBusy;
    logic clrBusy;
  } ctrlStrobe_t;

endpackage

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl
  import rxbd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        rxValid,
  input  logic        rxErr,
  input  logic        memAck,
  input  logic        rdEmpty,
  input  logic        countAtOne,
  input  logic        holdEof,
  output ctrlStrobe_t strb,
  output addrSel_t    addrSel,
  output logic        memReq,
  output logic        memWrite,
  output logic        memByte,
  output logic        bufOpen
);

  rxState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    addrSel   = ASEL_DESC0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    memByte   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (enable) nextState = ST_FETCH0;
      end
      ST_FETCH0: begin
        memReq  = 1'b1;
        addrSel = ASEL_DESC0;
        if (memAck) begin
          strb.takeHeader = 1'b1;
          if (rdEmpty) begin
            strb.clrBusy = 1'b1;
            nextState    = enable ? ST_FETCH1 : ST_IDLE;
          end else begin
            strb.setBusy = 1'b1;
            nextState    = enable ? ST_FETCH0 : ST_IDLE;
          end
        end
      end
      ST_FETCH1: begin
        memReq  = 1'b1;
        addrSel = ASEL_DESC1;
        if (memAck) begin
          strb.openBuffer = 1'b1;
          nextState       = enable ? ST_OPEN : ST_IDLE;
        end
      end
      ST_OPEN: begin
        if (!enable) begin
          nextState = ST_IDLE;
        end else if (rxValid) begin
          strb.captureByte = 1'b1;
          nextState        = rxErr ? ST_CLOSE : ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        memByte  = 1'b1;
        addrSel  = ASEL_DATA;
        if (memAck) begin
          strb.byteDone = 1'b1;
          nextState     = (holdEof || countAtOne) ? ST_CLOSE : ST_OPEN;
        end
      end
      ST_CLOSE: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        addrSel  = ASEL_DESC0;
        if (memAck) begin
          strb.closeDone = 1'b1;
          nextState      = enable ? ST_FETCH0 : ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign bufOpen = (state == ST_OPEN) || (state == ST_WRITE) || (state == ST_CLOSE);

  // R3: a request stays up, unchanged in kind, until the memory answers
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWrite) && $stable(memByte)));

  // R11: disabled and idle means silent on the memory port
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !memReq);

endmodule

// File: rtl/rxbd_datapath.sv
module rxbd_datapath
  import rxbd_pkg::*;
#(
  parameter int                 ADDR_W        = 32,
  parameter int                 LEN_W         = 16,
  parameter logic [ADDR_W-1:0]  RESET_BASE    = 32'h0000_0100,
  parameter logic [LEN_W-1:0]   RESET_MAX_LEN = 16'd16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [7:0]        rxData,
  input  logic              rxEof,
  input  logic              rxErr,
  input  ctrlStrobe_t       strb,
  input  addrSel_t          addrSel,
  input  logic              memByte,
  input  logic              bufOpen,
  input  logic [31:0]       memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWData,
  output logic              enable,
  output logic              countAtOne,
  output logic              holdEof,
  output logic              rxBusy
);

  localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(DESC_STRIDE);
  localparam logic [ADDR_W-1:0] W1_OFS   = ADDR_W'(WORD1_OFS);
  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);

  logic [LEN_W-1:0]  maxLenReg;
  logic [ADDR_W-1:0] ringBase;
  logic [ADDR_W-1:0] descPtr;
  logic [ADDR_W-1:0] dataPtr;
  logic [LEN_W-1:0]  downCount;
  logic [LEN_W-1:0]  openLimit;
  logic              descWrap;
  logic [7:0]        holdData;
  logic              holdErr;
  logic [LEN_W-1:0]  storedLen;
  logic [31:0]       closeWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable    <= 1'b0;
      maxLenReg <= RESET_MAX_LEN;
      ringBase  <= RESET_BASE;
      descPtr   <= RESET_BASE;
    end else begin
      if (cfgWrEn) begin
        case (cfgSel)
          SEL_MAXLEN: if (cfgWrData[LEN_W-1:0] != '0) maxLenReg <= cfgWrData[LEN_W-1:0];
          SEL_BASE:   ringBase <= cfgWrData;
          SEL_DPTR:   if (!bufOpen) descPtr <= cfgWrData;
          SEL_ENABLE: enable <= cfgWrData[0];
          default:    ;
        endcase
      end
      if (strb.closeDone) descPtr <= descWrap ? ringBase : descPtr + STRIDE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataPtr   <= '0;
      downCount <= '0;
      openLimit <= '0;
      descWrap  <= 1'b0;
      holdData  <= '0;
      holdEof   <= 1'b0;
      holdErr   <= 1'b0;
      rxBusy    <= 1'b0;
    end else begin
      if (strb.takeHeader) descWrap <= memRData[WRAP_BIT];
      if (strb.openBuffer) begin
        dataPtr   <= memRData[ADDR_W-1:0];
        downCount <= maxLenReg;
        openLimit <= maxLenReg;
        holdEof   <= 1'b0;
        holdErr   <= 1'b0;
      end
      if (strb.captureByte) begin
        holdData <= rxData;
        holdEof  <= rxEof;
        holdErr  <= rxErr;
      end
      if (strb.byteDone) begin
        dataPtr   <= dataPtr + ADDR_W'(1);
        downCount <= downCount - LEN_ONE;
      end
      if (strb.setBusy)      rxBusy <= 1'b1;
      else if (strb.clrBusy) rxBusy <= 1'b0;
    end
  end

  assign countAtOne = (downCount == LEN_ONE);
  assign storedLen  = openLimit - downCount;

  always_comb begin
    closeWord            = '0;
    closeWord[EMPTY_BIT] = 1'b0;
    closeWord[WRAP_BIT]  = descWrap;
    closeWord[LAST_BIT]  = holdEof;
    closeWord[ERR_BIT]   = holdErr;
    closeWord[15:0]      = 16'(storedLen);
  end

  always_comb begin
    case (addrSel)
      ASEL_DESC1: memAddr = descPtr + W1_OFS;
      ASEL_DATA:  memAddr = dataPtr;
      default:    memAddr = descPtr;
    endcase
  end

  assign memWData = memByte ? {24'h0, holdData} : closeWord;

  // R4: never write past the limit
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteDone |-> (downCount != '0));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    downCount <= openLimit);

  // R3: data pointer steps by one per stored byte
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteDone |=> (dataPtr == $past(dataPtr) + ADDR_W'(1)));

  // R7: ring advance and wrap reload
  assert_wrap_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.closeDone && descWrap) |=> (descPtr == $past(ringBase)));

  assert_ring_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.closeDone && !descWrap) |=> (descPtr == $past(descPtr) + STRIDE));

  // R8: the shared limit is never zero
  assert_maxlen_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
    maxLenReg != '0);

  // R9: pointer write refused while a buffer is open
  assert_ptr_guard_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == SEL_DPTR && bufOpen && !strb.closeDone) |=> $stable(descPtr));

  // R10: busy only while no buffer is held
  assert_busy_closed_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxBusy |-> !bufOpen);

endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine
  import rxbd_pkg::*;
#(
  parameter int                 ADDR_W        = 32,
  parameter int                 LEN_W         = 16,
  parameter logic [ADDR_W-1:0]  RESET_BASE    = 32'h0000_0100,
  parameter logic [LEN_W-1:0]   RESET_MAX_LEN = 16'd16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxEof,
  input  logic              rxErr,
  output logic              memReq,
  output logic              memWrite,
  output logic              memByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWData,
  input  logic              memAck,
  input  logic [31:0]       memRData,
  output logic              rxBusy
);

  ctrlStrobe_t strb;
  addrSel_t    addrSel;
  logic        enable;
  logic        countAtOne;
  logic        holdEof;
  logic        bufOpen;

  rxbd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .rxValid    (rxValid),
    .rxErr      (rxErr),
    .memAck     (memAck),
    .rdEmpty    (memRData[EMPTY_BIT]),
    .countAtOne (countAtOne),
    .holdEof    (holdEof),
    .strb       (strb),
    .addrSel    (addrSel),
    .memReq     (memReq),
    .memWrite   (memWrite),
    .memByte    (memByte),
    .bufOpen    (bufOpen)
  );

  rxbd_datapath #(
    .ADDR_W        (ADDR_W),
    .LEN_W         (LEN_W),
    .RESET_BASE    (RESET_BASE),
    .RESET_MAX_LEN (RESET_MAX_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgSel     (cfgSel),
    .cfgWrData  (cfgWrData),
    .rxData     (rxData),
    .rxEof      (rxEof),
    .rxErr      (rxErr),
    .strb       (strb),
    .addrSel    (addrSel),
    .memByte    (memByte),
    .bufOpen    (bufOpen),
    .memRData   (memRData),
    .memAddr    (memAddr),
    .memWData   (memWData),
    .enable     (enable),
    .countAtOne (countAtOne),
    .holdEof    (holdEof),
    .rxBusy     (rxBusy)
  );

endmodule

// File: tb/rxbd_engine_tb.sv
module rxbd_engine_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [31:0] cfgWrData = '0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxEof = 1'b0;
  logic        rxErr = 1'b0;
  logic        memReq, memWrite, memByte;
  logic [31:0] memAddr, memWData;
  logic        memAck = 1'b0;
  logic [31:0] memRData = '0;
  logic        rxBusy;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] mem [0:1023];
  int closeCount = 0;
  int byteWrites = 0;
  int readCount = 0;
  logic [31:0] firstRead = '0;
  logic [31:0] lastRead = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbd_engine dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .rxValid(rxValid), .rxData(rxData), .rxEof(rxEof), .rxErr(rxErr),
    .memReq(memReq), .memWrite(memWrite), .memByte(memByte), .memAddr(memAddr),
    .memWData(memWData), .memAck(memAck), .memRData(memRData), .rxBusy(rxBusy)
  );

  function automatic logic [31:0] rdWord(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wrWord(input int a, input logic [31:0] v);
    mem[a] = v[7:0]; mem[a+1] = v[15:8]; mem[a+2] = v[23:16]; mem[a+3] = v[31:24];
  endtask

  // memory model, answers at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (memReq && !memAck) begin
        int a;
        a = int'(memAddr[9:0]);
        memAck = 1'b1;
        if (memWrite && memByte) begin
          mem[a] = memWData[7:0];
          byteWrites++;
        end else if (memWrite) begin
          wrWord(a, memWData);
          closeCount++;
        end else begin
          memRData = rdWord(a);
          if (readCount == 0) firstRead = memAddr;
          lastRead = memAddr;
          readCount++;
        end
      end else begin
        memAck = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d, input logic eof, input logic err);
    @(negedge clk);
    rxValid = 1'b1; rxData = d; rxEof = eof; rxErr = err;
    @(negedge clk);
    rxValid = 1'b0; rxEof = 1'b0; rxErr = 1'b0;
    waitCycles(12);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic testReset();
    check("R1 memReq after reset", {31'b0, memReq}, 32'd0);
    check("R1 busy after reset", {31'b0, rxBusy}, 32'd0);
  endtask

  task automatic testLimit();
    cfgWrite(2'd0, 32'd4);
    cfgWrite(2'd3, 32'd1);
    waitCycles(20);
    check("R1 first descriptor read", firstRead, 32'h100);
    for (int i = 0; i < 4; i++) sendByte(8'hA0 + 8'(i), 1'b0, 1'b0);
    waitCycles(10);
    for (int i = 0; i < 4; i++) check("R3 buffer0 byte", {24'b0, mem[32'h200 + i]}, 32'hA0 + i);
    check("R4 R2 desc0 close word", rdWord(32'h100), 32'h0000_0004);
    check("R4 close count", closeCount, 1);
  endtask

  task automatic testEof();
    sendByte(8'hB0, 1'b0, 1'b0);
    sendByte(8'hB1, 1'b1, 1'b0);
    waitCycles(10);
    check("R5 desc1 short frame", rdWord(32'h108), 32'h2000_0002);
    check("R5 byte1", {24'b0, mem[32'h241]}, 32'hB1);
    check("R5 untouched after eof", {24'b0, mem[32'h242]}, 32'hEE);
    for (int i = 0; i < 4; i++) sendByte(8'hC0 + 8'(i), (i == 3), 1'b0);
    waitCycles(10);
    check("R5 eof on limit", rdWord(32'h110), 32'h2000_0004);
    check("R5 next still empty", rdWord(32'h118), 32'hC000_0000);
    check("R5 single close", closeCount, 3);
  endtask

  task automatic testErrWrapBusy();
    int bw;
    sendByte(8'h71, 1'b0, 1'b0);
    sendByte(8'h72, 1'b0, 1'b1);
    waitCycles(10);
    check("R6 desc3 error close", rdWord(32'h118), 32'h5000_0001);
    check("R6 error byte not stored", {24'b0, mem[32'h2C1]}, 32'hEE);
    check("R10 busy on full ring", {31'b0, rxBusy}, 32'd1);
    check("R7 wrap reloads base", lastRead, 32'h100);
    bw = byteWrites;
    sendByte(8'h99, 1'b0, 1'b0);
    check("R10 byte dropped while busy", byteWrites, bw);
    wrWord(32'h100, 32'h8000_0000);
    waitCycles(20);
    check("R10 busy clears", {31'b0, rxBusy}, 32'd0);
    sendByte(8'h55, 1'b1, 1'b0);
    waitCycles(10);
    check("R7 wrapped buffer byte", {24'b0, mem[32'h200]}, 32'h55);
    check("R7 desc0 reused", rdWord(32'h100), 32'h2000_0001);
  endtask

  task automatic testMaxLen();
    wrWord(32'h108, 32'h8000_0000);
    wrWord(32'h110, 32'h8000_0000);
    wrWord(32'h118, 32'hC000_0000);
    waitCycles(20);
    sendByte(8'h41, 1'b0, 1'b0);
    cfgWrite(2'd0, 32'd2);
    for (int i = 0; i < 3; i++) sendByte(8'h42 + 8'(i), 1'b0, 1'b0);
    waitCycles(10);
    check("R8 old limit kept", rdWord(32'h108), 32'h0000_0004);
    sendByte(8'h51, 1'b0, 1'b0);
    sendByte(8'h52, 1'b0, 1'b0);
    waitCycles(10);
    check("R8 new limit applied", rdWord(32'h110), 32'h0000_0002);
    cfgWrite(2'd0, 32'd0);
    sendByte(8'h61, 1'b0, 1'b0);
    sendByte(8'h62, 1'b0, 1'b0);
    waitCycles(10);
    check("R8 zero write ignored", rdWord(32'h118), 32'h4000_0002);
  endtask

  task automatic testPtrWrite();
    wrWord(32'h108, 32'h8000_0000);
    waitCycles(10);
    cfgWrite(2'd2, 32'h108);
    waitCycles(20);
    check("R9 pointer accepted when polling", {31'b0, rxBusy}, 32'd0);
    cfgWrite(2'd2, 32'h118);
    sendByte(8'h31, 1'b0, 1'b0);
    sendByte(8'h32, 1'b0, 1'b0);
    waitCycles(10);
    check("R9 close at open entry", rdWord(32'h108), 32'h0000_0002);
    check("R9 other entry untouched", rdWord(32'h118), 32'h4000_0002);
    check("R9 ring order kept", lastRead, 32'h110);
  endtask

  task automatic testDisabled();
    int bw;
    cfgWrite(2'd3, 32'd0);
    waitCycles(10);
    wrWord(32'h110, 32'h8000_0000);
    bw = byteWrites;
    sendByte(8'h66, 1'b0, 1'b0);
    check("R11 no request when disabled", {31'b0, memReq}, 32'd0);
    check("R11 byte dropped when disabled", byteWrites, bw);
    cfgWrite(2'd3, 32'd1);
    waitCycles(20);
    sendByte(8'h77, 1'b1, 1'b0);
    waitCycles(10);
    check("R11 first byte after enable", {24'b0, mem[32'h280]}, 32'h77);
    check("R11 desc2 close", rdWord(32'h110), 32'h2000_0001);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'hEE;
    for (int i = 0; i < 4; i++) begin
      wrWord(32'h100 + 8*i, (i == 3) ? 32'hC000_0000 : 32'h8000_0000);
      wrWord(32'h104 + 8*i, 32'h200 + 32'h40*i);
    end
    waitCycles(4);
    rstN = 1'b1;
    waitCycles(2);
    testReset();
    testLimit();
    testEof();
    testErrWrapBusy();
    testMaxLen();
    testPtrWrite();
    testDisabled();
    done = 1;
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

endmodule